// File: doc/BRIEF.md
# Overcurrent Fault Retry Supervisor

This block sequences fault protection for a driver with several bridges (two by default). Each bridge provides one raw overcurrent bit. The bit must stay high for a programmable number of consecutive clock cycles before the block treats it as a real fault. A confirmed fault switches off only that bridge. The block holds the bridge off for a fixed retry period and then releases it automatically. If the overcurrent is still present after the release, the filter and retry cycle starts again.

Two further single-bit inputs are shared by all bridges:

- **Over-temperature** switches off every bridge for as long as it is high. It does not disturb the overcurrent sequencers.
- **Undervoltage** switches off every bridge, raises a global logic reset and clears all sequencer state.

All active conditions combine into one active-low fault level. That level is intended to drive the enable of an open-drain pad. Every output is registered.

Top module: `ocp_retry_supervisor`

## Requirements
- R1: Confirmation needs the overcurrent bit of a bridge high on DG_CYC consecutive clock edges. `bridge_off` of that bridge rises on the edge after the DG_CYC-th such edge.
- R2: A single low sample of the overcurrent bit during filtering restarts the count from zero. Two high runs of DG_CYC-1 edges each, separated by one low edge, never switch the bridge off.
- R3: An overcurrent on one bridge leaves `bridge_off` of every other bridge at 0.
- R4: A confirmed bridge stays off for exactly RT_CYC cycles and is then released. `fault_n` returns to 1 on the same edge. While the bridge is locked, the overcurrent bit is ignored.
- R5: If the overcurrent bit is still high when the bridge is released, a new trip follows DG_CYC cycles later.
- R6: `overtemp` high switches all bridges off and drives `fault_n` to 0 one edge later. Both release one edge after it clears. A running retry period is unaffected.
- R7: `undervolt` high sets `logic_reset` and switches all bridges off one edge later. It also clears every sequencer, so a locked bridge does not wait out its retry period.
- R8: `fault_n` is 0 (pad pulled low) whenever any bridge is off for any reason, and 1 otherwise. When one bridge is released on the same edge that another trips, `fault_n` must not rise.
- R9: After synchronous `rst`, `bridge_off` is all 0, `fault_n` is 1 and `logic_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | NUM_BR | Raw overcurrent bit, one per bridge |
| overtemp | input | 1 | Over-temperature indication |
| undervolt | input | 1 | Supply undervoltage indication |
| bridge_off | output | NUM_BR | 1 disables all switches of that bridge |
| logic_reset | output | 1 | Global reset during undervoltage |
| fault_n | output | 1 | Active-low fault level for the open-drain pad enable |

## Verification
The two functions that can fall in the same cycle are the retry expiry on bridge 0 and the deglitch confirmation on bridge 1. The bench provokes this by starting the overcurrent on bridge 1 exactly RT_CYC cycles after it starts on bridge 0. As a result, one lock clears on the very edge the other sets. The check passes only if `fault_n` stays low on every sample across the handover, while each `bridge_off` bit follows its own window computed from DG_CYC and RT_CYC.

// File: rtl/ocp_sup_pkg.sv
package ocp_sup_pkg;
  typedef enum logic {
    BR_WATCH  = 1'b0,
    BR_LOCKED = 1'b1
  } br_state_t;
endpackage

// File: rtl/ocp_bridge_seq.sv
module ocp_bridge_seq
  import ocp_sup_pkg::*;
#(
  parameter int DG_CYC = 200,
  parameter int RT_CYC = 67500
) (
  input  logic clk,
  input  logic clr_i,
  input  logic oc_in,
  output logic lock_o
);
  localparam int DW = $clog2(DG_CYC + 1);
  localparam int RW = $clog2(RT_CYC + 1);
  localparam logic [DW-1:0] DG_LAST = DW'(DG_CYC - 1);
  localparam logic [RW-1:0] RT_LAST = RW'(RT_CYC - 1);

  br_state_t st_q;
  logic [DW-1:0] dg_q;
  logic [RW-1:0] rc_q;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      st_q <= BR_WATCH;
      dg_q <= '0;
      rc_q <= '0;
    end else begin
      case (st_q)
        BR_WATCH: begin
          rc_q <= '0;
          if (!oc_in) begin
            dg_q <= '0;
          end else if (dg_q == DG_LAST) begin
            dg_q <= '0;
            st_q <= BR_LOCKED;
          end else begin
            dg_q <= dg_q + 1'b1;
          end
        end
        default: begin
          dg_q <= '0;
          if (rc_q == RT_LAST) begin
            rc_q <= '0;
            st_q <= BR_WATCH;
          end else begin
            rc_q <= rc_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign lock_o = (st_q == BR_LOCKED);

  AST_LOW_BLOCKS_TRIP: assert property (@(posedge clk) disable iff (clr_i)
    (st_q == BR_WATCH && !oc_in) |=> (st_q == BR_WATCH)); // R2
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (clr_i)
    (st_q == BR_LOCKED && rc_q != RT_LAST) |=> (st_q == BR_LOCKED)); // R4
  AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (clr_i)
    (st_q == BR_LOCKED && rc_q == RT_LAST) |=> (st_q == BR_WATCH)); // R4
endmodule

// File: rtl/fault_merge.sv
module fault_merge #(
  parameter int NUM_BR = 2
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic [NUM_BR-1:0] lock_i,
  input  logic              ot_in,
  input  logic              uv_in,
  output logic [NUM_BR-1:0] bridge_off_o,
  output logic              logic_reset_o,
  output logic              fault_n_o
);
  logic global_off;
  assign global_off = ot_in | uv_in;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      bridge_off_o  <= '0;
      logic_reset_o <= 1'b0;
      fault_n_o     <= 1'b1;
    end else begin
      bridge_off_o  <= lock_i | {NUM_BR{global_off}};
      logic_reset_o <= uv_in;
      fault_n_o     <= ~((|lock_i) | global_off);
    end
  end

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (rst_i)
    uv_in |=> (logic_reset_o && (&bridge_off_o))); // R7
  AST_OT_FAULT_LOW: assert property (@(posedge clk) disable iff (rst_i)
    ot_in |=> (!fault_n_o && (&bridge_off_o))); // R6
  AST_LOCK_SHOWN: assert property (@(posedge clk) disable iff (rst_i)
    (|lock_i) |=> !fault_n_o); // R8
endmodule

// File: rtl/ocp_retry_supervisor.sv
module ocp_retry_supervisor #(
  parameter int NUM_BR = 2,
  parameter int DG_CYC = 200,
  parameter int RT_CYC = 67500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BR-1:0] oc_raw,
  input  logic              overtemp,
  input  logic              undervolt,
  output logic [NUM_BR-1:0] bridge_off,
  output logic              logic_reset,
  output logic              fault_n
);
  logic              seq_clr;
  logic [NUM_BR-1:0] lock;

  assign seq_clr = rst | undervolt;

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    ocp_bridge_seq #(
      .DG_CYC(DG_CYC),
      .RT_CYC(RT_CYC)
    ) u_seq (
      .clk   (clk),
      .clr_i (seq_clr),
      .oc_in (oc_raw[b]),
      .lock_o(lock[b])
    );
  end

  fault_merge #(
    .NUM_BR(NUM_BR)
  ) u_merge (
    .clk          (clk),
    .rst_i        (rst),
    .lock_i       (lock),
    .ot_in        (overtemp),
    .uv_in        (undervolt),
    .bridge_off_o (bridge_off),
    .logic_reset_o(logic_reset),
    .fault_n_o    (fault_n)
  );

  AST_UV_CLEARS_LOCK: assert property (@(posedge clk) disable iff (rst)
    undervolt |=> (lock == '0)); // R7
endmodule

// File: tb/ocp_retry_supervisor_test.sv
module ocp_retry_supervisor_test;
  localparam int D = 4;
  localparam int R = 8;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] oc_raw = '0;
  logic overtemp = 1'b0;
  logic undervolt = 1'b0;
  logic [1:0] bridge_off;
  logic logic_reset;
  logic fault_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  ocp_retry_supervisor #(.NUM_BR(2), .DG_CYC(D), .RT_CYC(R)) uut (
    .clk(clk), .rst(rst), .oc_raw(oc_raw), .overtemp(overtemp),
    .undervolt(undervolt), .bridge_off(bridge_off),
    .logic_reset(logic_reset), .fault_n(fault_n)
  );

  task automatic chk(input bit ok, input string req, input int n, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s sample=%0d act=%0d exp=%0d", req, n, act, exp);
    end
  endtask

  task automatic cmp(input int n, input bit e0, input bit e1, input bit er, input string req);
    chk(bridge_off[0] == e0, req, n, bridge_off[0], e0);
    chk(bridge_off[1] == e1, req, n, bridge_off[1], e1);
    chk(logic_reset == er, req, n, logic_reset, er);
    chk(fault_n == !(e0 | e1), {req, "/R8"}, n, fault_n, !(e0 | e1));
  endtask

  function automatic bit inw(input int n, input int lo, input int hi);
    return (n >= lo) && (n <= hi);
  endfunction

  task automatic idle(input int k);
    oc_raw = '0; overtemp = 1'b0; undervolt = 1'b0;
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    cmp(0, 1'b0, 1'b0, 1'b0, "R9");

    // R1 R3 R4 R5: sweep of overcurrent pulse length on bridge 0
    for (int L = 1; L <= 2 * D + R + 2; L++) begin
      for (int n = 0; n < 2 * D + 2 * R + 4; n++) begin
        @(negedge clk);
        cmp(n, (L >= D && inw(n, D + 1, D + R)) ||
               (L >= 2 * D + R && inw(n, 2 * D + R + 1, 2 * D + 2 * R)),
            1'b0, 1'b0, "R1_R3_R4_R5");
        oc_raw[0] = (n < L);
      end
      idle(2 * R + 2 * D);
    end

    // R2: low sample restarts deglitch
    for (int n = 0; n < 3 * D + 4; n++) begin
      @(negedge clk);
      cmp(n, 1'b0, 1'b0, 1'b0, "R2");
      oc_raw[1] = (n < D - 1) || (n >= D && n < 2 * D - 1);
    end
    idle(4);

    // R6: overtemp alone, then overtemp during a lock
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      cmp(n, inw(n, 1, 5), inw(n, 1, 5), 1'b0, "R6");
      overtemp = (n < 5);
    end
    idle(4);
    for (int n = 0; n < D + R + 4; n++) begin
      @(negedge clk);
      cmp(n, inw(n, D + 1, D + R) || inw(n, 3, 4), inw(n, 3, 4), 1'b0, "R6_lock");
      oc_raw[0] = (n < D);
      overtemp = (n >= 2 && n < 4);
    end
    idle(2 * R);

    // R7: undervoltage cuts a retry short
    for (int n = 0; n < D + R + 4; n++) begin
      @(negedge clk);
      cmp(n, inw(n, D + 1, D + 4), inw(n, D + 3, D + 4), inw(n, D + 3, D + 4), "R7");
      oc_raw[0] = (n < D);
      undervolt = (n >= D + 2 && n < D + 4);
    end
    idle(2 * R);

    // R8: release of bridge 0 coincides with trip of bridge 1
    for (int n = 0; n < 2 * R + D + 4; n++) begin
      @(negedge clk);
      cmp(n, inw(n, D + 1, D + R), inw(n, R + D + 1, 2 * R + D), 1'b0, "R8_handover");
      oc_raw[0] = (n < D);
      oc_raw[1] = (n >= R && n < R + D);
    end
    idle(4);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule